// File: doc/BRIEF.md
# Banked Program Counter with Deferred Bank Select

This block holds the 12-bit instruction address of a small controller whose 4K-word program store is split into two 2K halves. The top address bit picks the half and the lower eleven bits address a word inside it. Counting forward never leaves the current half. To move to the other half, software first records its choice in a pending-bank flip-flop. That choice is applied only when the next jump or call loads the counter.

Subroutine calls and interrupts save the full 12-bit address on an internal 8-entry return stack, and returns restore it. While an interrupt is being serviced, the counter is confined to the lower half. The pending-bank flip-flop can still be changed during that time, and the change shows up at the first jump or call after the service routine ends. Instruction decoding and the program store itself are outside this block. The block receives one strobe per operation.

Top module: `banked_pc`

## Requirements
- R1: When the advance strobe is the only operation in a cycle, bits 10:0 of the counter increase by one and bit 11 keeps its value, so 7FFh becomes 000h and FFFh becomes 800h.
- R2: The select-high strobe sets the pending-bank flip-flop and the select-low strobe clears it. When both are asserted in the same cycle, select-low wins. Neither strobe changes the counter. The flip-flop is visible on `bank_pend_o`.
- R3: Outside interrupt service, a jump loads the counter with {pending bank, 11-bit target}. It uses the flip-flop value from before that clock edge.
- R4: A call loads the counter the same way as a jump and pushes {bit 11, bits 10:0 + 1} of the current counter. A return pops all 12 bits back into the counter. The pending-bank flip-flop is not changed by a call or a return.
- R5: An interrupt taken outside service loads address 003h when `vec_sel_i` is 0 and 007h when it is 1. It pushes the current counter and raises `in_isr_o`. While `in_isr_o` is high, bit 11 of the counter is 0, including after jumps, calls and returns.
- R6: A bank select made during interrupt service changes the flip-flop and leaves bit 11 at 0. The new bank takes effect at the first jump after the service ends.
- R7: An interrupt strobe that arrives during service is ignored: the counter, the stack and `in_isr_o` are unchanged by it.
- R8: Return-from-interrupt pops all 12 bits into the counter and lowers `in_isr_o`.
- R9: The return stack holds 8 entries, and its pointer wraps. A ninth unbroken push overwrites the oldest entry, so nine pops return the last eight pushes newest first and then the ninth push again.
- R10: An active-low asynchronous reset clears the counter to 000h, the pending-bank flip-flop to 0, `in_isr_o` to 0 and the stack pointer to 0.
- R11: Only one counter operation is carried out per cycle, in this priority: interrupt taken, call, jump, return-from-interrupt, return, advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_i | input | 1 | Advance strobe |
| jmp_i | input | 1 | Jump strobe |
| call_i | input | 1 | Call strobe |
| tgt_i | input | 11 | Jump or call target within a half |
| bsel_lo_i | input | 1 | Select lower half at next jump or call |
| bsel_hi_i | input | 1 | Select upper half at next jump or call |
| irq_i | input | 1 | Interrupt strobe |
| vec_sel_i | input | 1 | Vector choice: 0 gives 003h, 1 gives 007h |
| ret_i | input | 1 | Return strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| pc_o | output | 12 | Current program counter |
| bank_pend_o | output | 1 | Pending-bank flip-flop |
| in_isr_o | output | 1 | Interrupt service in progress |

## Verification
The hardest case to reach is a bank select made inside a service routine. The counter itself must stay in the lower half, and the deferred choice must still appear after return-from-interrupt. The stimulus therefore first enters the upper half, takes an interrupt, and changes the flip-flop while in service. It then jumps and calls inside the routine and checks that bit 11 stays at 0. After the routine ends, a plain jump shows the new bank. Stack wrap is reached with nine calls in a row followed by nine returns. A second interrupt strobe is also issued during service to confirm that it is ignored.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

   typedef enum logic [2:0] {
      ACT_HOLD,
      ACT_INC,
      ACT_JUMP,
      ACT_CALL,
      ACT_IRQ,
      ACT_RET,
      ACT_RETI
   } pc_act_e;

endpackage

// File: rtl/bpc_bank_ff.sv
module bpc_bank_ff (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_lo,
   input  logic sel_hi,
   output logic bank_q
);

   // select-low has priority over select-high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bank_q <= 1'b0;
      else if (sel_lo)
         bank_q <= 1'b0;
      else if (sel_hi)
         bank_q <= 1'b1;
   end

endmodule

// File: rtl/bpc_ret_stack.sv
module bpc_ret_stack #(
   parameter int WIDTH = 12,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] top_data
);

   localparam int SP_W = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << SP_W) != DEPTH) begin : g_bad_depth
         $error("bpc_ret_stack: DEPTH must be a power of two of at least 2");
      end
      if (WIDTH < 2) begin : g_bad_width
         $error("bpc_ret_stack: WIDTH must be at least 2");
      end
   endgenerate

   logic [SP_W-1:0]  sp_q;
   logic [SP_W-1:0]  sp_top;
   logic [WIDTH-1:0] ent_q [DEPTH];

   assign sp_top = sp_q - 1'b1;

   // pointer wraps silently in both directions
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sp_q <= '0;
      else if (push)
         sp_q <= sp_q + 1'b1;
      else if (pop)
         sp_q <= sp_top;
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ent_q[i] <= '0;
            else if (push && sp_q == SP_W'(i))
               ent_q[i] <= push_data;
         end
      end
   endgenerate

   assign top_data = ent_q[sp_top];

endmodule

// File: rtl/bpc_next.sv
module bpc_next
   import bpc_pkg::*;
#(
   parameter int PC_W = 12,
   parameter int VEC0 = 3,
   parameter int VEC1 = 7
) (
   input  logic            [PC_W-1:0] pc_q,
   input  logic                       isr_q,
   input  logic                       bank_q,
   input  logic                       inc,
   input  logic                       jmp,
   input  logic                       call,
   input  logic            [PC_W-2:0] tgt,
   input  logic                       irq,
   input  logic                       vec_sel,
   input  logic                       ret,
   input  logic                       reti,
   input  logic            [PC_W-1:0] pop_data,
   output logic            [PC_W-1:0] pc_d,
   output logic                       isr_d,
   output logic                       push,
   output logic            [PC_W-1:0] push_data,
   output logic                       pop
);

   localparam int LOW_W = PC_W - 1;
   localparam logic [LOW_W-1:0] VA = LOW_W'(VEC0);
   localparam logic [LOW_W-1:0] VB = LOW_W'(VEC1);

   generate
      if (VEC0 >= (1 << LOW_W) || VEC1 >= (1 << LOW_W)) begin : g_bad_vec
         $error("bpc_next: vectors must lie inside one bank");
      end
   endgenerate

   pc_act_e          act;
   logic             hi_bit;
   logic [LOW_W-1:0] low_inc;

   // bank bit for loads: forced low while servicing
   assign hi_bit  = bank_q & ~isr_q;
   assign low_inc = pc_q[LOW_W-1:0] + 1'b1;

   always_comb begin
      if (irq && !isr_q)  act = ACT_IRQ;
      else if (call)      act = ACT_CALL;
      else if (jmp)       act = ACT_JUMP;
      else if (reti)      act = ACT_RETI;
      else if (ret)       act = ACT_RET;
      else if (inc)       act = ACT_INC;
      else                act = ACT_HOLD;
   end

   always_comb begin
      pc_d      = pc_q;
      isr_d     = isr_q;
      push      = 1'b0;
      pop       = 1'b0;
      push_data = pc_q;
      unique case (act)
         ACT_INC:  pc_d = {pc_q[PC_W-1], low_inc};
         ACT_JUMP: pc_d = {hi_bit, tgt};
         ACT_CALL: begin
            pc_d      = {hi_bit, tgt};
            push      = 1'b1;
            push_data = {pc_q[PC_W-1], low_inc};
         end
         ACT_IRQ: begin
            pc_d      = {1'b0, (vec_sel ? VB : VA)};
            push      = 1'b1;
            push_data = pc_q;
            isr_d     = 1'b1;
         end
         ACT_RET: begin
            pop  = 1'b1;
            pc_d = {pop_data[PC_W-1] & ~isr_q, pop_data[LOW_W-1:0]};
         end
         ACT_RETI: begin
            pop   = 1'b1;
            pc_d  = pop_data;
            isr_d = 1'b0;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/banked_pc.sv
module banked_pc #(
   parameter int PC_W  = 12,
   parameter int DEPTH = 8,
   parameter int VEC0  = 3,
   parameter int VEC1  = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inc_i,
   input  logic            jmp_i,
   input  logic            call_i,
   input  logic [PC_W-2:0] tgt_i,
   input  logic            bsel_lo_i,
   input  logic            bsel_hi_i,
   input  logic            irq_i,
   input  logic            vec_sel_i,
   input  logic            ret_i,
   input  logic            reti_i,
   output logic [PC_W-1:0] pc_o,
   output logic            bank_pend_o,
   output logic            in_isr_o
);

   generate
      if (PC_W < 4) begin : g_bad_pc
         $error("banked_pc: PC_W must be at least 4");
      end
   endgenerate

   logic [PC_W-1:0] pc_q, pc_d;
   logic            isr_q, isr_d;
   logic            bank_q;
   logic            push, pop;
   logic [PC_W-1:0] push_data, top_data;

   bpc_bank_ff u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_lo (bsel_lo_i),
      .sel_hi (bsel_hi_i),
      .bank_q (bank_q)
   );

   bpc_ret_stack #(.WIDTH(PC_W), .DEPTH(DEPTH)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (push_data),
      .pop       (pop),
      .top_data  (top_data)
   );

   bpc_next #(.PC_W(PC_W), .VEC0(VEC0), .VEC1(VEC1)) u_next (
      .pc_q      (pc_q),
      .isr_q     (isr_q),
      .bank_q    (bank_q),
      .inc       (inc_i),
      .jmp       (jmp_i),
      .call      (call_i),
      .tgt       (tgt_i),
      .irq       (irq_i),
      .vec_sel   (vec_sel_i),
      .ret       (ret_i),
      .reti      (reti_i),
      .pop_data  (top_data),
      .pc_d      (pc_d),
      .isr_d     (isr_d),
      .push      (push),
      .push_data (push_data),
      .pop       (pop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         isr_q <= 1'b0;
      end else begin
         pc_q  <= pc_d;
         isr_q <= isr_d;
      end
   end

   assign pc_o        = pc_q;
   assign bank_pend_o = bank_q;
   assign in_isr_o    = isr_q;

endmodule

// File: rtl/banked_pc_chk.sv
module banked_pc_chk #(
   parameter int PC_W = 12,
   parameter int VEC0 = 3,
   parameter int VEC1 = 7
) (
   input logic            clk,
   input logic            rst_n,
   input logic            inc_i,
   input logic            jmp_i,
   input logic            call_i,
   input logic [PC_W-2:0] tgt_i,
   input logic            bsel_lo_i,
   input logic            bsel_hi_i,
   input logic            irq_i,
   input logic            vec_sel_i,
   input logic            ret_i,
   input logic            reti_i,
   input logic [PC_W-1:0] pc_o,
   input logic            bank_pend_o,
   input logic            in_isr_o
);

   localparam int LOW_W = PC_W - 1;

   logic take_irq;
   logic only_inc;
   assign take_irq = irq_i & ~in_isr_o;
   assign only_inc = inc_i & ~jmp_i & ~call_i & ~ret_i & ~reti_i & ~take_irq;

   p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      only_inc |=> (pc_o[PC_W-1] == $past(pc_o[PC_W-1]))
                && (pc_o[LOW_W-1:0] == $past(pc_o[LOW_W-1:0]) + 1'b1));

   p_sel_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bsel_hi_i && !bsel_lo_i) |=> bank_pend_o);

   p_sel_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bsel_lo_i |=> !bank_pend_o);

   p_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (jmp_i && !call_i && !take_irq && !in_isr_o)
      |=> pc_o == {$past(bank_pend_o), $past(tgt_i)});

   p_call_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && !take_irq && !in_isr_o)
      |=> pc_o == {$past(bank_pend_o), $past(tgt_i)});

   p_ret_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !bsel_lo_i && !bsel_hi_i) |=> $stable(bank_pend_o));

   p_bit11_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_isr_o |-> !pc_o[PC_W-1]);

   p_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |=> in_isr_o
                && (pc_o == ($past(vec_sel_i) ? PC_W'(VEC1) : PC_W'(VEC0))));

   p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_i && in_isr_o && !inc_i && !jmp_i && !call_i && !ret_i && !reti_i)
      |=> $stable(pc_o) && in_isr_o);

   p_reti_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_i && !take_irq && !call_i && !jmp_i) |=> !in_isr_o);

endmodule

bind banked_pc banked_pc_chk #(.PC_W(PC_W), .VEC0(VEC0), .VEC1(VEC1)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .inc_i       (inc_i),
   .jmp_i       (jmp_i),
   .call_i      (call_i),
   .tgt_i       (tgt_i),
   .bsel_lo_i   (bsel_lo_i),
   .bsel_hi_i   (bsel_hi_i),
   .irq_i       (irq_i),
   .vec_sel_i   (vec_sel_i),
   .ret_i       (ret_i),
   .reti_i      (reti_i),
   .pc_o        (pc_o),
   .bank_pend_o (bank_pend_o),
   .in_isr_o    (in_isr_o)
);

// File: tb/banked_pc_bench.sv
module banked_pc_bench;

   localparam int CLK_P = 10;
   localparam int NV    = 27;

   // op codes used by the table
   localparam logic [3:0] OP_INC = 4'd1, OP_JMP = 4'd2, OP_CALL = 4'd3,
                          OP_SB0 = 4'd4, OP_SB1 = 4'd5, OP_IRQ = 4'd6,
                          OP_RET = 4'd7, OP_RETI = 4'd8, OP_PRIO = 4'd9,
                          OP_BOTH = 4'd10;

   // {op, vec_sel, arg[10:0], exp_bank, 2'b0, exp_isr, exp_pc[11:0]}
   localparam logic [31:0] TBL [NV] = '{
      {OP_INC,  1'b0, 11'h000, 1'b0, 2'b00, 1'b0, 12'h001},
      {OP_JMP,  1'b0, 11'h7FE, 1'b0, 2'b00, 1'b0, 12'h7FE},
      {OP_INC,  1'b0, 11'h000, 1'b0, 2'b00, 1'b0, 12'h7FF},
      {OP_INC,  1'b0, 11'h000, 1'b0, 2'b00, 1'b0, 12'h000},
      {OP_SB1,  1'b0, 11'h000, 1'b1, 2'b00, 1'b0, 12'h000},
      {OP_JMP,  1'b0, 11'h010, 1'b1, 2'b00, 1'b0, 12'h810},
      {OP_INC,  1'b0, 11'h000, 1'b1, 2'b00, 1'b0, 12'h811},
      {OP_CALL, 1'b0, 11'h123, 1'b1, 2'b00, 1'b0, 12'h923},
      {OP_SB0,  1'b0, 11'h000, 1'b0, 2'b00, 1'b0, 12'h923},
      {OP_RET,  1'b0, 11'h000, 1'b0, 2'b00, 1'b0, 12'h812},
      {OP_JMP,  1'b0, 11'h7FF, 1'b0, 2'b00, 1'b0, 12'h7FF},
      {OP_SB1,  1'b0, 11'h000, 1'b1, 2'b00, 1'b0, 12'h7FF},
      {OP_JMP,  1'b0, 11'h7FF, 1'b1, 2'b00, 1'b0, 12'hFFF},
      {OP_INC,  1'b0, 11'h000, 1'b1, 2'b00, 1'b0, 12'h800},
      {OP_IRQ,  1'b0, 11'h000, 1'b1, 2'b00, 1'b1, 12'h003},
      {OP_JMP,  1'b0, 11'h050, 1'b1, 2'b00, 1'b1, 12'h050},
      {OP_SB0,  1'b0, 11'h000, 1'b0, 2'b00, 1'b1, 12'h050},
      {OP_SB1,  1'b0, 11'h000, 1'b1, 2'b00, 1'b1, 12'h050},
      {OP_CALL, 1'b0, 11'h060, 1'b1, 2'b00, 1'b1, 12'h060},
      {OP_RET,  1'b0, 11'h000, 1'b1, 2'b00, 1'b1, 12'h051},
      {OP_IRQ,  1'b1, 11'h000, 1'b1, 2'b00, 1'b1, 12'h051},
      {OP_RETI, 1'b0, 11'h000, 1'b1, 2'b00, 1'b0, 12'h800},
      {OP_JMP,  1'b0, 11'h001, 1'b1, 2'b00, 1'b0, 12'h801},
      {OP_IRQ,  1'b1, 11'h000, 1'b1, 2'b00, 1'b1, 12'h007},
      {OP_RETI, 1'b0, 11'h000, 1'b1, 2'b00, 1'b0, 12'h801},
      {OP_PRIO, 1'b0, 11'h222, 1'b1, 2'b00, 1'b0, 12'hA22},
      {OP_BOTH, 1'b0, 11'h000, 1'b0, 2'b00, 1'b0, 12'hA22}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        inc_i = 0, jmp_i = 0, call_i = 0, bsel_lo_i = 0, bsel_hi_i = 0;
   logic        irq_i = 0, vec_sel_i = 0, ret_i = 0, reti_i = 0;
   logic [10:0] tgt_i = '0;
   logic [11:0] pc_o;
   logic        bank_pend_o, in_isr_o;

   int errors = 0;
   int checks = 0;
   bit done   = 0;

   always #(CLK_P/2) clk = ~clk;

   banked_pc u_banked_pc (
      .clk (clk), .rst_n (rst_n), .inc_i (inc_i), .jmp_i (jmp_i),
      .call_i (call_i), .tgt_i (tgt_i), .bsel_lo_i (bsel_lo_i),
      .bsel_hi_i (bsel_hi_i), .irq_i (irq_i), .vec_sel_i (vec_sel_i),
      .ret_i (ret_i), .reti_i (reti_i), .pc_o (pc_o),
      .bank_pend_o (bank_pend_o), .in_isr_o (in_isr_o)
   );

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         OP_INC:          return "R1";
         OP_SB0, OP_SB1,
         OP_BOTH:         return "R2";
         OP_JMP:          return "R3";
         OP_CALL, OP_RET: return "R4";
         OP_IRQ:          return "R5";
         OP_RETI:         return "R8";
         default:         return "R11";
      endcase
   endfunction

   task automatic check(input string tag, input logic [11:0] pc_e,
                        input logic bank_e, input logic isr_e);
      checks++;
      if (pc_o !== pc_e || bank_pend_o !== bank_e || in_isr_o !== isr_e) begin
         errors++;
         $display("FAIL %s: pc=%h bank=%b isr=%b expected pc=%h bank=%b isr=%b",
                  tag, pc_o, bank_pend_o, in_isr_o, pc_e, bank_e, isr_e);
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic vs, input logic [10:0] arg);
      @(negedge clk);
      tgt_i     = arg;
      vec_sel_i = vs;
      case (op)
         OP_INC:  inc_i = 1;
         OP_JMP:  jmp_i = 1;
         OP_CALL: call_i = 1;
         OP_SB0:  bsel_lo_i = 1;
         OP_SB1:  bsel_hi_i = 1;
         OP_IRQ:  irq_i = 1;
         OP_RET:  ret_i = 1;
         OP_RETI: reti_i = 1;
         OP_PRIO: begin inc_i = 1; jmp_i = 1; end
         OP_BOTH: begin bsel_lo_i = 1; bsel_hi_i = 1; end
         default: ;
      endcase
      @(negedge clk);
      {inc_i, jmp_i, call_i, bsel_lo_i, bsel_hi_i, irq_i, ret_i, reti_i} = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      repeat (2) @(negedge clk);
      // R10: reset state
      check("R10", 12'h000, 1'b0, 1'b0);
      rst_n = 1;

      // table walk
      for (int i = 0; i < NV; i++) begin
         apply(TBL[i][31:28], TBL[i][27], TBL[i][26:16]);
         check(tag_of(TBL[i][31:28]), TBL[i][11:0], TBL[i][15], TBL[i][12]);
      end

      // R10: reset from a busy state (in service, bank high)
      apply(OP_IRQ, 1'b0, 11'h0);
      apply(OP_SB1, 1'b0, 11'h0);
      do_reset();
      check("R10", 12'h000, 1'b0, 1'b0);

      // R6: select inside service keeps bit 11 low, applies after return
      apply(OP_JMP, 1'b0, 11'h200);
      apply(OP_IRQ, 1'b1, 11'h0);
      apply(OP_SB1, 1'b0, 11'h0);
      apply(OP_JMP, 1'b0, 11'h040);
      check("R6", 12'h040, 1'b1, 1'b1);
      apply(OP_RETI, 1'b0, 11'h0);
      check("R8", 12'h200, 1'b1, 1'b0);
      apply(OP_JMP, 1'b0, 11'h040);
      check("R6", 12'h840, 1'b1, 1'b0);

      // R7: second interrupt during service is ignored
      apply(OP_IRQ, 1'b0, 11'h0);
      check("R5", 12'h003, 1'b1, 1'b1);
      apply(OP_IRQ, 1'b1, 11'h0);
      check("R7", 12'h003, 1'b1, 1'b1);
      apply(OP_RETI, 1'b0, 11'h0);
      check("R7", 12'h840, 1'b1, 1'b0);

      // R9: nine calls then nine returns, stack wraps
      do_reset();
      for (int k = 0; k < 9; k++) begin
         apply(OP_CALL, 1'b0, 11'(12'h100 + k));
         check("R9", 12'(12'h100 + k), 1'b0, 1'b0);
      end
      for (int k = 0; k < 9; k++) begin
         apply(OP_RET, 1'b0, 11'h0);
         check("R9", (k == 8) ? 12'h108 : 12'(12'h108 - k), 1'b0, 1'b0);
      end

      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            if (!done) begin
               errors++;
               checks++;
               $display("FAIL watchdog: run did not finish, expected completion");
            end
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule